// File: doc/BRIEF.md
# Serial-Link Display-Side Read Responder and i80 Bus Regenerator

This block sits next to one or two display peripherals at the far end of a two-lane, double-edge serial link. It decodes the short frames the host-side end sends, rebuilds i80-style bus cycles for the peripherals (data, address/data select, two active-low chip selects, read and write strobes), and answers read commands by sending the peripheral word back on the same two lanes at single-edge rate. The rebuilt strobe widths depend on serial clock cycles only, never on how the host drove its own strobe.

Each serial clock cycle delivers four bits: `lane_a` holds the two lane bits seen on the rising half and `lane_b` the two lane bits seen on the falling half. An idle line reads high on all four. A read command makes the block take the lanes for its reply: it releases them, drives them high, sends a low start bit, sends eight payload cycles, drives high for one cycle and releases them again. After that the master must idle the lanes high before the next frame.

The peripheral side has no flow control. Every cycle has a fixed length, so the host must keep at least five serial cycles between writes. It must also not send a new frame while a read reply is in progress.

Top module: `slv_link_responder`

## Requirements
- R1: While reset is applied, and on the cycle after `pd_n` is sampled low, `dout` is all zeros, `ad`, `cs1_n`, `cs2_n`, `rd_n` and `wr_n` are 1, and `tx_oe` is 0.
- R2: Frame cycle 0 carries the frame header: `lane_a[0]`=0 is the start bit, `lane_a[1]` is 1 for read and 0 for write, `lane_b[0]` is the address/data bit and `lane_b[1]` is 1 to select CS1 and 0 to select CS2. A write then takes four more cycles. In data cycle k (0..3), lane 0 carries data bits 2k (`lane_a`) and 2k+1 (`lane_b`), and lane 1 carries bits 8+2k and 9+2k. The clock edge that samples the last data cycle is E4. `dout`, `ad` and the chip selects take the frame's values after E5.
- R3: For a write, `wr_n` is low after edges E6, E7 and E8 and high again after E9, so it is low for exactly 3 cycles. `rd_n` and `wr_n` are never low together.
- R4: `dout`, `ad` and the chip selects keep their values after a cycle ends and do not change while a strobe is low. The selected chip select stays low until a transaction selects the other one or a power-down occurs. Both chip selects are never low together.
- R5: For a read command sampled at edge E0, `ad` and the chip selects update after E1 and `rd_n` is low after E2 through E4. `rd_data` is captured at E5, the edge where `rd_n` rises.
- R6: If `idr` is 1 when the command is sampled, two reads run back to back: `rd_n` is low after E2..E4, high after E5, and low again after E6..E8. Only the word captured at E9 is returned. The start bit moves 10 cycles later.
- R7: After a read command the lanes turn around: `tx_oe` is 0 after E1 and E2, and is 1 with `tx_bit`=2'b11 from E3 until the start bit. This is well before the 14th half-cycle edge.
- R8: The start bit (`tx_oe`=1, `tx_bit`=2'b00) follows E8, or E18 with `idr`=1. The next 8 cycles carry payload bit k on `tx_bit[0]` as data bit k and on `tx_bit[1]` as data bit 8+k, least significant first, one bit per cycle.
- R9: After the payload the lanes are driven 2'b11 for one cycle and then released (`tx_oe`=0).
- R10: A header cycle that is not all high but has `lane_a[0]`=1 is treated as a malformed frame. The block then ignores all lane activity, including lows that look like start bits, until it sees a cycle with all four bits high.
- R11: A power-down in the middle of a read reply or a strobe returns every output to the R1 values at once. After `pd_n` rises, the block accepts frames again.
- R12: Writes sent back to back, 5 cycles apart, each produce their own 3-cycle `wr_n` pulse. The second write's values appear after E10, with no lost or merged strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Synchronous active-low power-down |
| lane_a | input | 2 | Lane bits seen on the rising half of the cycle ([0]=lane 0) |
| lane_b | input | 2 | Lane bits seen on the falling half of the cycle |
| idr | input | 1 | Insert a dummy peripheral read ahead of the real one |
| rd_data | input | 16 | Read data from the peripheral |
| dout | output | 16 | Write data bus to the peripheral |
| ad | output | 1 | Address/data select |
| cs1_n | output | 1 | Chip select 1, active low |
| cs2_n | output | 1 | Chip select 2, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| tx_oe | output | 1 | Drive enable for the return lanes (0 = lanes off) |
| tx_bit | output | 2 | Return lane levels ([0]=lane 0) |

## Verification
Two functions can land in the same cycle. One is the strobe engine holding `wr_n` low for one write. The other is the frame decoder taking in the header and data of the next write. This is provoked by sending two writes with no gap, 5 cycles apart, so the second header is sampled at E5, exactly when the first write's values are loaded. The test passes only if both 3-cycle pulses appear at their computed edges, the bus shows the first word through E9 and the second from E10, and the chip select swaps only at that load. A second overlap is a power-down that arrives while the reply is on the lanes and a peripheral read is pending. All outputs must be at their idle values on the very next cycle.

// File: rtl/slv_link_pkg.sv
package slv_link_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_DATA,
    RX_RESYNC
  } rx_state_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW
  } stb_state_e;

  typedef struct packed {
    logic ad;
    logic sel1;
    logic dummy;
  } link_cmd_t;

endpackage

// File: rtl/slv_frame_rx.sv
module slv_frame_rx
  import slv_link_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          busy,
  input  logic [1:0]    lane_a,
  input  logic [1:0]    lane_b,
  input  logic          idr,
  output logic          wr_evt,
  output logic          rd_evt,
  output link_cmd_t     cmd,
  output logic [DW-1:0] wr_data
);

  localparam int LW   = DW / 2;
  localparam int NCYC = LW / 2;
  localparam int CW   = $clog2(NCYC + 1);

  rx_state_e     state;
  logic [CW-1:0] cyc;
  logic          all_high;

  assign all_high = (lane_a == 2'b11) && (lane_b == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cyc     <= '0;
      wr_evt  <= 1'b0;
      rd_evt  <= 1'b0;
      cmd     <= '0;
      wr_data <= '0;
    end else if (clr) begin
      state   <= RX_IDLE;
      cyc     <= '0;
      wr_evt  <= 1'b0;
      rd_evt  <= 1'b0;
      cmd     <= '0;
      wr_data <= '0;
    end else begin
      wr_evt <= 1'b0;
      rd_evt <= 1'b0;
      if (busy) begin
        state <= RX_RESYNC;
      end else begin
        case (state)
          RX_IDLE: begin
            if (!lane_a[0]) begin
              cmd.ad    <= lane_b[0];
              cmd.sel1  <= lane_b[1];
              cmd.dummy <= idr;
              if (lane_a[1]) begin
                rd_evt <= 1'b1;
              end else begin
                state <= RX_DATA;
                cyc   <= '0;
              end
            end else if (!all_high) begin
              state <= RX_RESYNC;
            end
          end
          RX_DATA: begin
            for (int j = 0; j < NCYC; j++) begin
              if (cyc == CW'(j)) begin
                wr_data[2*j]        <= lane_a[0];
                wr_data[2*j+1]      <= lane_b[0];
                wr_data[LW+2*j]     <= lane_a[1];
                wr_data[LW+2*j+1]   <= lane_b[1];
              end
            end
            if (cyc == CW'(NCYC - 1)) begin
              wr_evt <= 1'b1;
              state  <= RX_IDLE;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
          default: begin
            if (all_high) state <= RX_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/slv_strobe_gen.sv
module slv_strobe_gen
  import slv_link_pkg::*;
#(
  parameter int DW         = 16,
  parameter int STROBE_LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_evt,
  input  logic          rd_evt,
  input  link_cmd_t     cmd,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout,
  output logic          ad,
  output logic          cs1_n,
  output logic          cs2_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] cap_data
);

  localparam int SW = $clog2(STROBE_LEN + 1);

  stb_state_e    state;
  logic [SW-1:0] cnt;
  logic          is_rd;
  logic          more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      is_rd    <= 1'b0;
      more     <= 1'b0;
      dout     <= '0;
      ad       <= 1'b1;
      cs1_n    <= 1'b1;
      cs2_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      cap_data <= '0;
    end else if (clr) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      is_rd    <= 1'b0;
      more     <= 1'b0;
      dout     <= '0;
      ad       <= 1'b1;
      cs1_n    <= 1'b1;
      cs2_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      cap_data <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wr_evt || rd_evt) begin
            ad    <= cmd.ad;
            cs1_n <= !cmd.sel1;
            cs2_n <= cmd.sel1;
            is_rd <= rd_evt;
            more  <= rd_evt && cmd.dummy;
            state <= ST_SETUP;
            if (wr_evt) dout <= wr_data;
          end
        end
        ST_SETUP: begin
          if (is_rd) rd_n <= 1'b0;
          else       wr_n <= 1'b0;
          cnt   <= SW'(1);
          state <= ST_LOW;
        end
        default: begin
          if (cnt == SW'(STROBE_LEN)) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            if (is_rd && !more) cap_data <= rd_data;
            if (more) begin
              more  <= 1'b0;
              state <= ST_SETUP;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/slv_return_tx.sv
module slv_return_tx #(
  parameter int DW          = 16,
  parameter int TA_OFF      = 2,
  parameter int RET_START   = 8,
  parameter int DUMMY_EXTRA = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rd_evt,
  input  logic          dummy,
  input  logic [DW-1:0] cap_data,
  output logic          active,
  output logic          tx_oe,
  output logic [1:0]    tx_bit
);

  localparam int LW   = DW / 2;
  localparam int MAXN = RET_START + DUMMY_EXTRA + LW + 2;
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] start_at;
  logic [LW-1:0] sh0;
  logic [LW-1:0] sh1;

  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      start_at <= '0;
      sh0      <= '0;
      sh1      <= '0;
      tx_oe    <= 1'b0;
      tx_bit   <= 2'b11;
    end else if (clr) begin
      active   <= 1'b0;
      cnt      <= '0;
      start_at <= '0;
      sh0      <= '0;
      sh1      <= '0;
      tx_oe    <= 1'b0;
      tx_bit   <= 2'b11;
    end else if (rd_evt) begin
      active   <= 1'b1;
      cnt      <= CW'(1);
      start_at <= dummy ? CW'(RET_START + DUMMY_EXTRA) : CW'(RET_START);
      tx_oe    <= 1'b0;
      tx_bit   <= 2'b11;
    end else if (active) begin
      cnt <= cnt_nx;
      if (cnt_nx <= CW'(TA_OFF)) begin
        tx_oe <= 1'b0;
      end else if (cnt_nx < start_at) begin
        tx_oe  <= 1'b1;
        tx_bit <= 2'b11;
      end else if (cnt_nx == start_at) begin
        tx_oe  <= 1'b1;
        tx_bit <= 2'b00;
        sh0    <= cap_data[LW-1:0];
        sh1    <= cap_data[DW-1:LW];
      end else if (cnt_nx <= start_at + CW'(LW)) begin
        tx_bit <= {sh1[0], sh0[0]};
        sh0    <= sh0 >> 1;
        sh1    <= sh1 >> 1;
      end else if (cnt_nx == start_at + CW'(LW + 1)) begin
        tx_bit <= 2'b11;
      end else begin
        tx_oe  <= 1'b0;
        active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/slv_link_responder.sv
module slv_link_responder
  import slv_link_pkg::*;
#(
  parameter int DW          = 16,
  parameter int STROBE_LEN  = 3,
  parameter int TA_OFF      = 2,
  parameter int RET_START   = 8,
  parameter int DUMMY_EXTRA = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic [1:0]    lane_a,
  input  logic [1:0]    lane_b,
  input  logic          idr,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout,
  output logic          ad,
  output logic          cs1_n,
  output logic          cs2_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          tx_oe,
  output logic [1:0]    tx_bit
);

  logic          clr;
  logic          wr_evt;
  logic          rd_evt;
  logic          tx_active;
  logic          busy;
  link_cmd_t     cmd;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] cap_data;

  assign clr  = !pd_n;
  assign busy = tx_active || rd_evt;

  slv_frame_rx #(.DW(DW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .busy    (busy),
    .lane_a  (lane_a),
    .lane_b  (lane_b),
    .idr     (idr),
    .wr_evt  (wr_evt),
    .rd_evt  (rd_evt),
    .cmd     (cmd),
    .wr_data (wr_data)
  );

  slv_strobe_gen #(.DW(DW), .STROBE_LEN(STROBE_LEN)) u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wr_evt   (wr_evt),
    .rd_evt   (rd_evt),
    .cmd      (cmd),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .dout     (dout),
    .ad       (ad),
    .cs1_n    (cs1_n),
    .cs2_n    (cs2_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .cap_data (cap_data)
  );

  slv_return_tx #(
    .DW(DW), .TA_OFF(TA_OFF), .RET_START(RET_START), .DUMMY_EXTRA(DUMMY_EXTRA)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rd_evt   (rd_evt),
    .dummy    (cmd.dummy),
    .cap_data (cap_data),
    .active   (tx_active),
    .tx_oe    (tx_oe),
    .tx_bit   (tx_bit)
  );

endmodule

// File: rtl/slv_link_responder_chk.sv
module slv_link_responder_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_n,
  input logic [DW-1:0] dout,
  input logic          ad,
  input logic          cs1_n,
  input logic          cs2_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          tx_oe,
  input logic [1:0]    tx_bit
);

  logic [3:0] wr_run;
  logic [3:0] rd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run <= '0;
      rd_run <= '0;
    end else begin
      wr_run <= !wr_n ? ((wr_run == 4'hF) ? wr_run : wr_run + 1'b1) : '0;
      rd_run <= !rd_n ? ((rd_run == 4'hF) ? rd_run : rd_run + 1'b1) : '0;
    end
  end

  // R1 / R11: power-down forces idle levels on the next cycle
  p_pd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (dout == '0 && ad && cs1_n && cs2_n && rd_n && wr_n && !tx_oe));

  p_cs_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs1_n && !cs2_n));

  p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_wr_len_r3: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    ($rose(wr_n) && $past(pd_n)) |-> (wr_run == 4'd3));

  p_rd_len_r5: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    ($rose(rd_n) && $past(pd_n)) |-> (rd_run == 4'd3));

  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    !wr_n |-> ($stable(dout) && $stable(ad) && $stable(cs1_n) && $stable(cs2_n)));

  p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    (!tx_oe && $past(tx_oe) && $past(pd_n)) |-> ($past(tx_bit) == 2'b11));

endmodule

bind slv_link_responder slv_link_responder_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pd_n   (pd_n),
  .dout   (dout),
  .ad     (ad),
  .cs1_n  (cs1_n),
  .cs2_n  (cs2_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .tx_oe  (tx_oe),
  .tx_bit (tx_bit)
);

// File: tb/slv_link_responder_tb.sv
module slv_link_responder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pd_n;
  logic [1:0]  lane_a;
  logic [1:0]  lane_b;
  logic        idr;
  logic [15:0] rd_data;
  logic [15:0] dout;
  logic        ad, cs1_n, cs2_n, rd_n, wr_n, tx_oe;
  logic [1:0]  tx_bit;

  int errs   = 0;
  int checks = 0;

  always #10 clk = ~clk;

  slv_link_responder u_dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .lane_a(lane_a), .lane_b(lane_b),
    .idr(idr), .rd_data(rd_data), .dout(dout), .ad(ad), .cs1_n(cs1_n),
    .cs2_n(cs2_n), .rd_n(rd_n), .wr_n(wr_n), .tx_oe(tx_oe), .tx_bit(tx_bit)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lanes_idle();
    lane_a = 2'b11;
    lane_b = 2'b11;
  endtask

  task automatic set_wr_cycle(int c, logic sel1, logic adv, logic [15:0] d);
    if (c == 0) begin
      lane_a = 2'b00;
      lane_b = {sel1, adv};
    end else begin
      lane_a = {d[8+2*(c-1)], d[2*(c-1)]};
      lane_b = {d[9+2*(c-1)], d[2*(c-1)+1]};
    end
  endtask

  task automatic check_idle(string req);
    check(req, "dout", dout, 16'h0000);
    check(req, "ad/cs1_n/cs2_n/rd_n/wr_n", {ad, cs1_n, cs2_n, rd_n, wr_n}, 5'b11111);
    check(req, "tx_oe", tx_oe, 1'b0);
  endtask

  // one complete write; checks load and strobe timing
  task automatic do_write(string req, logic sel1, logic adv, logic [15:0] d);
    for (int c = 0; c < 5; c++) begin
      set_wr_cycle(c, sel1, adv, d);
      tick();
    end
    lanes_idle();
    tick();  // after E5
    check(req, "dout after load", dout, d);
    check(req, "ad after load", ad, adv);
    check(req, "cs1_n/cs2_n after load", {cs1_n, cs2_n}, {!sel1, sel1});
    check("R3", "wr_n before pulse", wr_n, 1'b1);
    for (int e = 6; e <= 8; e++) begin
      tick();
      check("R3", "wr_n low window", wr_n, 1'b0);
    end
    tick();
    check("R3", "wr_n after pulse", wr_n, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pd_n = 1'b1; idr = 1'b0; rd_data = '0;
    lanes_idle();
    repeat (3) tick();
    check_idle("R1");
    rst_n = 1'b1;
    repeat (2) tick();
    check_idle("R1");
  endtask

  task automatic t_write_basic();
    do_write("R2", 1'b1, 1'b1, 16'hA5C3);
    do_write("R2", 1'b1, 1'b0, 16'h0F71);
  endtask

  task automatic t_hold_and_swap();
    repeat (6) tick();
    check("R4", "dout held", dout, 16'h0F71);
    check("R4", "cs1 held low", {cs1_n, cs2_n}, 2'b01);
    do_write("R4", 1'b0, 1'b1, 16'h3C5A);
    repeat (3) tick();
    check("R4", "cs2 held low after swap", {cs1_n, cs2_n}, 2'b10);
  endtask

  task automatic t_back_to_back();
    logic [15:0] d1 = 16'h1234;
    logic [15:0] d2 = 16'hFEDC;
    for (int t = 0; t < 16; t++) begin
      if (t < 5)       set_wr_cycle(t, 1'b1, 1'b1, d1);
      else if (t < 10) set_wr_cycle(t - 5, 1'b0, 1'b0, d2);
      else             lanes_idle();
      tick();
      if (t >= 5) begin
        check("R12", "wr_n back-to-back", wr_n,
              ((t >= 6 && t <= 8) || (t >= 11 && t <= 13)) ? 1'b0 : 1'b1);
        check("R12", "dout back-to-back", dout, (t >= 10) ? d2 : d1);
        check("R12", "cs back-to-back", {cs1_n, cs2_n}, (t >= 10) ? 2'b10 : 2'b01);
      end
    end
  endtask

  task automatic t_read(logic dummy, logic [15:0] first, logic [15:0] real_word);
    int s;
    string rq;
    s  = dummy ? 18 : 8;
    rq = dummy ? "R6" : "R5";
    idr     = dummy;
    rd_data = dummy ? first : real_word;
    lane_a  = 2'b10;
    lane_b  = 2'b00;
    tick();  // E0
    lanes_idle();
    for (int n = 1; n <= s + 11; n++) begin
      logic       exp_rd;
      logic [2:0] exp_tx;
      string      tr;
      tick();
      if (n == 1) begin
        check(rq, "cs2 selected, ad=0", {cs1_n, cs2_n, ad}, 3'b100);
      end
      exp_rd = !((n >= 2 && n <= 4) || (dummy && n >= 6 && n <= 8));
      check(rq, "rd_n sequence", rd_n, exp_rd);
      if (n <= 2) begin
        exp_tx = 3'b011; tr = "R7";
      end else if (n < s) begin
        exp_tx = 3'b111; tr = "R7";
      end else if (n == s) begin
        exp_tx = 3'b100; tr = "R8";
      end else if (n <= s + 8) begin
        exp_tx = {1'b1, real_word[8+n-s-1], real_word[n-s-1]}; tr = "R8";
      end else if (n == s + 9) begin
        exp_tx = 3'b111; tr = "R9";
      end else begin
        exp_tx = 3'b011; tr = "R9";
      end
      if (exp_tx[2]) check(tr, "tx_oe/tx_bit", {tx_oe, tx_bit}, exp_tx);
      else           check(tr, "tx_oe", tx_oe, 1'b0);
      if (dummy && n == 5) rd_data = real_word;
    end
    idr = 1'b0;
    repeat (2) tick();
  endtask

  task automatic t_malformed();
    logic [15:0] keep;
    keep   = dout;
    lane_a = 2'b01;  // lane 1 low, lane 0 high: not a start bit
    lane_b = 2'b11;
    tick();
    for (int c = 0; c < 5; c++) begin
      set_wr_cycle(c, 1'b1, 1'b0, 16'h0000);
      tick();
    end
    lanes_idle();
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R10", "no strobe while resyncing", wr_n, 1'b1);
    end
    check("R10", "dout untouched", dout, keep);
    do_write("R10", 1'b1, 1'b1, 16'h8001);
  endtask

  task automatic t_powerdown();
    idr     = 1'b1;
    rd_data = 16'hBEEF;
    lane_a  = 2'b10;
    lane_b  = 2'b11;
    tick();
    lanes_idle();
    repeat (6) tick();
    pd_n = 1'b0;
    tick();
    check_idle("R11");
    pd_n = 1'b1;
    idr  = 1'b0;
    tick();
    check_idle("R11");
    do_write("R11", 1'b0, 1'b0, 16'h5555);
  endtask

  initial begin
    t_reset();
    t_write_basic();
    t_hold_and_swap();
    t_back_to_back();
    t_read(1'b0, 16'h0000, 16'hC3A6);
    t_read(1'b1, 16'h1111, 16'h6B2D);
    t_malformed();
    t_powerdown();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule